// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Early Address Steering

This block is the fetch and decode control of a small processor. It sits between a byte-wide memory and a register file of sixteen 32-bit entries. The memory has a registered read address and returns the addressed byte two clock edges after that address is loaded. The block puts each 16-bit instruction together from two bytes, collects any trailing immediate or offset bytes, and retires the instruction with its result word.

Its main feature is early steering. The opcode sits in the first instruction byte. The block decodes that byte in the same cycle it arrives, before the second instruction byte has been captured. From that decode it either keeps the read address counting upward, so that trailing bytes arrive during decode and the first execute cycle, or it reloads the address from the stack pointer (register 14) for a pop. A load through a register-sum address has to wait for the addition in the decode cycle, so it starts its read only after decode.

Each retired instruction is reported on a one-cycle retire bundle. The bundle carries the opcode, the destination field, the result word and the instruction's own address. The block also writes its internal register file.

Top module: `fseq_top`

## Requirements
- R1: A synchronous active-low reset clears the program counter, the read address and every register to zero and drops retire_valid. The block then passes once through an address-load cycle, so the first instruction after reset takes one cycle more than its normal count.
- R2: An address on mem_raddr during cycle c is captured from mem_rdata at the end of cycle c+1. Instructions and data are big-endian. The byte at the instruction address is {opcode[7:4], dest[3:0]} and the next byte is {srcA[7:4], srcB[3:0]}. Multi-byte words are shifted in most-significant byte first.
- R3: Opcode 0 (register move) writes register srcA into dest, reports that value, and takes 4 cycles.
- R4: Opcode 4 (pop) puts register 14 on mem_raddr in the third cycle of the instruction. It reads four bytes from there and writes the word to dest. It then adds 4 to register 14, which takes precedence if dest is 14. It takes 7 cycles, and fetch resumes at the instruction address plus 2.
- R5: Opcode 3 (load immediate) keeps the read address counting through the four bytes after the instruction. The instruction address plus 2 is on mem_raddr in the third cycle, and the instruction address plus 5 in the sixth. The word is written to dest. It takes 7 cycles and the next instruction is at the instruction address plus 6.
- R6: Opcode 2 (branch setup) reads the two bytes after the instruction and reports them sign-extended to 32 bits. It writes no register, takes 5 cycles, and the next instruction is at the instruction address plus 4.
- R7: Opcode 1 (load through register sum) puts the sum of registers srcA and srcB, truncated to the address width, on mem_raddr in the fifth cycle. It reads a big-endian word from there into dest and takes 9 cycles.
- R8: Opcodes 5 to 15 take 4 cycles, report a zero result word, write no register, and advance the program counter by 2.
- R9: retire_valid pulses for one cycle, in the cycle right after an instruction's last cycle. In that cycle retire_pc holds the instruction's address, retire_opcode and retire_dest hold its first-byte fields, and mem_raddr already holds the next instruction's address.
- R10: During fetch, the read address rises by one from the first instruction cycle to the second, and from the third to the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_raddr | output | ADDR_W | Registered byte read address to memory |
| mem_rdata | input | 8 | Byte returned by memory, two edges after the address is loaded |
| retire_valid | output | 1 | One-cycle pulse per retired instruction |
| retire_opcode | output | 4 | Opcode of the retired instruction |
| retire_dest | output | 4 | Destination field of the retired instruction |
| retire_data | output | WORD_W | Result word: moved value, loaded word, immediate, or sign-extended offset |
| retire_pc | output | ADDR_W | Address of the retired instruction |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 32-bit words, sixteen registers and the stack pointer at index 14. A 256-byte memory model backs it, and the model adds the one register of read latency. With these values every opcode class can be reached in one short program, along with its exact cycle count, the steering of the read address in the third and fifth cycles, big-endian assembly, sign extension of a negative offset, and two pops in a row that show the stack pointer moving by four. Address wrap at the top of the 16-bit space is not reached with this memory size.

// File: rtl/fseq_pkg.sv
// Package: shared state encoding, opcode values and the trailing-byte count
// used by the fetch sequencer and its checker.
// Assumes 16-bit instructions whose high byte carries the opcode in bits 7:4.
package fseq_pkg;

    typedef enum logic [3:0] {
        ST_F1,   // load read address from program counter (after reset only)
        ST_F2,   // first instruction cycle, address of high byte on the bus
        ST_F3,   // high byte arrives, opcode decoded, steering decided
        ST_F4,   // low byte arrives
        ST_DEC,  // register operands read and added
        ST_E1,
        ST_E2,
        ST_E3,
        ST_E4,
        ST_E5
    } fseq_state_e;

    localparam logic [3:0] OP_MOVE   = 4'd0;
    localparam logic [3:0] OP_LOADL  = 4'd1;
    localparam logic [3:0] OP_SETBRA = 4'd2;
    localparam logic [3:0] OP_LOADIL = 4'd3;
    localparam logic [3:0] OP_POP    = 4'd4;

    localparam int unsigned OFFSET_BYTES = 2;

    // Number of bytes that follow the instruction word for a given opcode.
    function automatic logic [3:0] trail_bytes(input logic [3:0] op,
                                               input logic [3:0] imm_bytes);
        logic [3:0] n;
        case (op)
            OP_SETBRA: n = 4'(OFFSET_BYTES);
            OP_LOADIL: n = imm_bytes;
            default:   n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
// Module: fseq_ctrl
// Walks the fetch, decode and execute states of one instruction and flags the
// last cycle of each instruction. Assumes op_q is valid from ST_DEC onward
// (captured at the end of ST_F3).
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  op_q,
    output fseq_state_e state,
    output logic        last
);

    fseq_state_e nxt;

    // Next-state selection per opcode class.
    always_comb begin
        nxt = state;
        case (state)
            ST_F1:  nxt = ST_F2;
            ST_F2:  nxt = ST_F3;
            ST_F3:  nxt = ST_F4;
            ST_F4:  nxt = ST_DEC;
            ST_DEC: nxt = (op_q inside {OP_LOADL, OP_SETBRA, OP_LOADIL, OP_POP})
                          ? ST_E1 : ST_F2;
            ST_E1:  nxt = (op_q == OP_SETBRA) ? ST_F2 : ST_E2;
            ST_E2:  nxt = ST_E3;
            ST_E3:  nxt = (op_q == OP_LOADL) ? ST_E4 : ST_F2;
            ST_E4:  nxt = ST_E5;
            ST_E5:  nxt = ST_F2;
            default: nxt = ST_F1;
        endcase
    end

    // Last cycle of an instruction: the next state starts a new fetch.
    assign last = (nxt == ST_F2) && (state != ST_F1);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_F1;
        else        state <= nxt;
    end

endmodule

// File: rtl/fseq_assemble.sv
// Module: fseq_assemble
// Captures the two instruction bytes and shifts trailing or loaded bytes into
// a word, most-significant byte first. Assumes each byte is presented on
// mem_rdata in the cycle after its address was on the read address bus.
module fseq_assemble
    import fseq_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fseq_state_e       state,
    input  logic [7:0]        mem_rdata,
    output logic [3:0]        op_q,
    output logic [3:0]        rd_q,
    output logic [3:0]        ra_q,
    output logic [3:0]        rb_q,
    output logic [WORD_W-1:0] word_now
);

    logic [WORD_W-1:0] acc;
    logic              cap;

    // Byte capture windows: register-sum loads wait for the address add.
    always_comb begin
        if (op_q == OP_LOADL)
            cap = state inside {ST_E2, ST_E3, ST_E4, ST_E5};
        else if (op_q inside {OP_POP, OP_LOADIL, OP_SETBRA})
            cap = state inside {ST_DEC, ST_E1, ST_E2, ST_E3};
        else
            cap = 1'b0;
    end

    // Word including the byte arriving in this cycle.
    assign word_now = {acc[WORD_W-9:0], mem_rdata};

    // Instruction byte and data shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            rd_q <= '0;
            ra_q <= '0;
            rb_q <= '0;
            acc  <= '0;
        end else begin
            if (state == ST_F3) begin
                op_q <= mem_rdata[7:4];
                rd_q <= mem_rdata[3:0];
            end
            if (state == ST_F4) begin
                ra_q <= mem_rdata[7:4];
                rb_q <= mem_rdata[3:0];
                acc  <= '0;
            end else if (cap) begin
                acc <= word_now;
            end
        end
    end

endmodule

// File: rtl/fseq_addr.sv
// Module: fseq_addr
// Owns the memory read address and the program counter. Decides in ST_F3,
// from the opcode then arriving, whether to keep counting or reload from the
// stack pointer; loads the register-sum address at the end of ST_DEC.
// Assumes pc holds the address of the instruction in flight.
module fseq_addr
    import fseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fseq_state_e       state,
    input  logic              last,
    input  logic [3:0]        op_early,
    input  logic [3:0]        op_q,
    input  logic [WORD_W-1:0] sp,
    input  logic [WORD_W-1:0] ea,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [3:0]        IMM_BYTES = 4'(WORD_W / 8);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);

    logic [ADDR_W-1:0] pc_next;

    // Address of the following instruction.
    assign pc_next = pc + INSN_BYTES + ADDR_W'(trail_bytes(op_q, IMM_BYTES));

    // Read address steering and program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr <= '0;
            pc    <= '0;
        end else if (last) begin
            raddr <= pc_next;
            pc    <= pc_next;
        end else begin
            case (state)
                ST_F1:   raddr <= pc;
                ST_F3:   raddr <= (op_early == OP_POP) ? ADDR_W'(sp) : raddr + 1'b1;
                ST_DEC:  raddr <= (op_q == OP_LOADL) ? ADDR_W'(ea) : raddr + 1'b1;
                default: raddr <= raddr + 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fseq_regfile.sv
// Module: fseq_regfile
// General register file with two combinational read ports, a stack pointer
// read port, one write port and a stack pointer increment. Assumes the
// increment wins over a write to the same entry.
module fseq_regfile #(
    parameter int unsigned REG_CNT  = 16,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned SP_INDEX = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(REG_CNT)-1:0] sel_a,
    input  logic [$clog2(REG_CNT)-1:0] sel_b,
    output logic [WORD_W-1:0]          data_a,
    output logic [WORD_W-1:0]          data_b,
    output logic [WORD_W-1:0]          sp,
    input  logic                       wr_en,
    input  logic [$clog2(REG_CNT)-1:0] wr_sel,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       sp_inc
);

    localparam logic [WORD_W-1:0] POP_STEP = WORD_W'(WORD_W / 8);

    logic [WORD_W-1:0] regs [REG_CNT];

    // Read ports.
    assign data_a = regs[sel_a];
    assign data_b = regs[sel_b];
    assign sp     = regs[SP_INDEX];

    // Write port and stack pointer step, the step taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
        end else begin
            if (wr_en)  regs[wr_sel]   <= wr_data;
            if (sp_inc) regs[SP_INDEX] <= regs[SP_INDEX] + POP_STEP;
        end
    end

endmodule

// File: rtl/fseq_top.sv
// Module: fseq_top
// Instruction fetch sequencer: joins state control, byte assembly, address
// steering and the register file, and registers the retire bundle.
// Assumes memory returns the byte for an address one cycle after that address
// is presented on mem_raddr, and that ADDR_W does not exceed WORD_W.
module fseq_top
    import fseq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned REG_CNT  = 16,
    parameter int unsigned SP_INDEX = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              retire_valid,
    output logic [3:0]        retire_opcode,
    output logic [3:0]        retire_dest,
    output logic [WORD_W-1:0] retire_data,
    output logic [ADDR_W-1:0] retire_pc
);

    localparam int unsigned SEL_W = $clog2(REG_CNT);

    fseq_state_e       state_q;
    logic              last;
    logic [3:0]        op_q, rd_q, ra_q, rb_q;
    logic [WORD_W-1:0] word_now;
    logic [WORD_W-1:0] rf_a, rf_b, sp, ea;
    logic [ADDR_W-1:0] pc;
    logic              wr_en, sp_inc;
    logic [WORD_W-1:0] result;

    fseq_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op_q  (op_q),
        .state (state_q),
        .last  (last)
    );

    fseq_assemble #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_q),
        .mem_rdata (mem_rdata),
        .op_q      (op_q),
        .rd_q      (rd_q),
        .ra_q      (ra_q),
        .rb_q      (rb_q),
        .word_now  (word_now)
    );

    // Register-sum operand address, formed in the decode cycle.
    assign ea = rf_a + rf_b;

    fseq_addr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .last     (last),
        .op_early (mem_rdata[7:4]),
        .op_q     (op_q),
        .sp       (sp),
        .ea       (ea),
        .raddr    (mem_raddr),
        .pc       (pc)
    );

    // Result word per opcode class.
    always_comb begin
        case (op_q)
            OP_MOVE:                     result = rf_a;
            OP_LOADL, OP_LOADIL, OP_POP: result = word_now;
            OP_SETBRA:                   result = {{(WORD_W-16){word_now[15]}}, word_now[15:0]};
            default:                     result = '0;
        endcase
    end

    // Register write and stack step happen on the last instruction cycle.
    assign wr_en  = last && (op_q inside {OP_MOVE, OP_LOADL, OP_LOADIL, OP_POP});
    assign sp_inc = last && (op_q == OP_POP);

    fseq_regfile #(.REG_CNT(REG_CNT), .WORD_W(WORD_W), .SP_INDEX(SP_INDEX)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_a   (SEL_W'(ra_q)),
        .sel_b   (SEL_W'(rb_q)),
        .data_a  (rf_a),
        .data_b  (rf_b),
        .sp      (sp),
        .wr_en   (wr_en),
        .wr_sel  (SEL_W'(rd_q)),
        .wr_data (result),
        .sp_inc  (sp_inc)
    );

    // Retire bundle register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_valid  <= 1'b0;
            retire_opcode <= '0;
            retire_dest   <= '0;
            retire_data   <= '0;
            retire_pc     <= '0;
        end else begin
            retire_valid <= last;
            if (last) begin
                retire_opcode <= op_q;
                retire_dest   <= rd_q;
                retire_data   <= result;
                retire_pc     <= pc;
            end
        end
    end

endmodule

// File: rtl/fseq_checker.sv
// Module: fseq_checker
// Temporal checks on the fetch sequencer, attached by bind.
module fseq_checker
    import fseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input fseq_state_e       state,
    input logic [ADDR_W-1:0] mem_raddr,
    input logic [7:0]        mem_rdata,
    input logic [WORD_W-1:0] sp,
    input logic              retire_valid,
    input logic [3:0]        retire_opcode,
    input logic [ADDR_W-1:0] retire_pc
);

    localparam logic [3:0] IMM_BYTES = 4'(WORD_W / 8);

    AST_LOAD_STATE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_F1) |=> (state != ST_F1));                               // R1

    AST_POP_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F3 && mem_rdata[7:4] == OP_POP)
        |=> (mem_raddr == ADDR_W'($past(sp))));                               // R4

    AST_RETIRE_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (state == ST_F2));                                   // R9

    AST_RETIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> !retire_valid);                                      // R9

    AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (mem_raddr == retire_pc + ADDR_W'(2)
                          + ADDR_W'(trail_bytes(retire_opcode, IMM_BYTES)))); // R9

    AST_FETCH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F2 || state == ST_F4)
        |=> (mem_raddr == $past(mem_raddr) + 1'b1));                          // R10

endmodule

bind fseq_top fseq_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .mem_raddr     (mem_raddr),
    .mem_rdata     (mem_rdata),
    .sp            (sp),
    .retire_valid  (retire_valid),
    .retire_opcode (retire_opcode),
    .retire_pc     (retire_pc)
);

// File: tb/tb_fseq_top.sv
`timescale 1ns/100ps
module tb_fseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_raddr;
    logic [7:0]  mem_rdata;
    logic        retire_valid;
    logic [3:0]  retire_opcode, retire_dest;
    logic [31:0] retire_data;
    logic [15:0] retire_pc;

    logic [7:0]  mem [0:255];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] hist [0:63];
    int          hlen;
    logic [15:0] carry;
    bit          hung = 1'b0;

    always #2.5 clk = ~clk;

    // Memory model: one register of read latency.
    always @(posedge clk) mem_rdata <= mem[mem_raddr[7:0]];

    fseq_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_raddr     (mem_raddr),
        .mem_rdata     (mem_rdata),
        .retire_valid  (retire_valid),
        .retire_opcode (retire_opcode),
        .retire_dest   (retire_dest),
        .retire_data   (retire_data),
        .retire_pc     (retire_pc)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Collect read addresses per cycle until the next retire pulse.
    task automatic wait_retire();
        hist[0] = carry;
        hlen = 1;
        forever begin
            @(negedge clk);
            if (retire_valid) begin
                carry = mem_raddr;
                break;
            end
            if (hlen < 64) hist[hlen] = mem_raddr;
            hlen++;
            if (hlen > 40) begin
                hung = 1'b1;
                check_eq("R9", "retire timeout", 32'(hlen), 32'd0);
                break;
            end
        end
    endtask

    task automatic expect_instr(input string req, input bit first,
                                input logic [15:0] pc, input logic [3:0] op,
                                input logic [3:0] dst, input logic [31:0] data,
                                input int len, input logic [15:0] next_pc);
        wait_retire();
        check_eq(req, "cycle count", 32'(hlen), 32'(len + (first ? 1 : 0)));
        check_eq("R9", "retire_pc", 32'(retire_pc), 32'(pc));
        check_eq("R9", "retire_opcode", 32'(retire_opcode), 32'(op));
        check_eq("R9", "retire_dest", 32'(retire_dest), 32'(dst));
        check_eq(req, "retire_data", retire_data, data);
        check_eq("R9", "next address on retire", 32'(carry), 32'(next_pc));
        if (!first) begin
            check_eq("R9", "first cycle address", 32'(hist[0]), 32'(pc));
            check_eq("R10", "second cycle address", 32'(hist[1]), 32'(pc + 16'd1));
        end
    endtask

    task automatic put(input int a, input logic [7:0] b);
        mem[a] = b;
    endtask

    task automatic load_program();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        put(0, 8'h31); put(1, 8'h00); put(2, 8'h11); put(3, 8'h22); put(4, 8'h33); put(5, 8'h44);
        put(6, 8'h3E); put(7, 8'h00); put(8, 8'h00); put(9, 8'h00); put(10, 8'h00); put(11, 8'h90);
        put(12, 8'h32); put(13, 8'h00); put(14, 8'h00); put(15, 8'h00); put(16, 8'h00); put(17, 8'h80);
        put(18, 8'h33); put(19, 8'h00); put(20, 8'h00); put(21, 8'h00); put(22, 8'h00); put(23, 8'h04);
        put(24, 8'h04); put(25, 8'h10);
        put(26, 8'h15); put(27, 8'h23);
        put(28, 8'h20); put(29, 8'h00); put(30, 8'hFF); put(31, 8'hF0);
        put(32, 8'h46); put(33, 8'h00);
        put(34, 8'h47); put(35, 8'h00);
        put(36, 8'h9A); put(37, 8'hBC);
        put(38, 8'h08); put(39, 8'h70);
        put(40, 8'h09); put(41, 8'hA0);
        put(132, 8'hDE); put(133, 8'hAD); put(134, 8'hBE); put(135, 8'hEF);
        put(144, 8'hCA); put(145, 8'hFE); put(146, 8'h00); put(147, 8'h01);
        put(148, 8'h12); put(149, 8'h34); put(150, 8'h56); put(151, 8'h78);
    endtask

    // R1: reset state, then release.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "retire_valid in reset", 32'(retire_valid), 32'd0);
        check_eq("R1", "read address in reset", 32'(mem_raddr), 32'd0);
        carry = mem_raddr;
        rst_n = 1'b1;
    endtask

    // R5: immediate loads, first one carrying the extra cycle of R1.
    task automatic t_load_imm();
        expect_instr("R1", 1'b1, 16'h0000, 4'h3, 4'h1, 32'h11223344, 7, 16'h0006);
        expect_instr("R5", 1'b0, 16'h0006, 4'h3, 4'hE, 32'h00000090, 7, 16'h000C);
        check_eq("R5", "third cycle address", 32'(hist[2]), 32'h0008);
        check_eq("R5", "sixth cycle address", 32'(hist[5]), 32'h000B);
        expect_instr("R5", 1'b0, 16'h000C, 4'h3, 4'h2, 32'h00000080, 7, 16'h0012);
        expect_instr("R5", 1'b0, 16'h0012, 4'h3, 4'h3, 32'h00000004, 7, 16'h0018);
    endtask

    // R3: register move.
    task automatic t_move();
        expect_instr("R3", 1'b0, 16'h0018, 4'h0, 4'h4, 32'h11223344, 4, 16'h001A);
    endtask

    // R7 and R2: load through a register sum, big-endian.
    task automatic t_load_long();
        expect_instr("R7", 1'b0, 16'h001A, 4'h1, 4'h5, 32'hDEADBEEF, 9, 16'h001C);
        check_eq("R7", "fifth cycle address", 32'(hist[4]), 32'h0084);
        check_eq("R2", "sixth cycle address", 32'(hist[5]), 32'h0085);
    endtask

    // R6: branch setup offset, negative.
    task automatic t_branch_setup();
        expect_instr("R6", 1'b0, 16'h001C, 4'h2, 4'h0, 32'hFFFFFFF0, 5, 16'h0020);
    endtask

    // R4: two pops, the second reading four bytes higher.
    task automatic t_pop();
        expect_instr("R4", 1'b0, 16'h0020, 4'h4, 4'h6, 32'hCAFE0001, 7, 16'h0022);
        check_eq("R4", "stack address in third cycle", 32'(hist[2]), 32'h0090);
        expect_instr("R4", 1'b0, 16'h0022, 4'h4, 4'h7, 32'h12345678, 7, 16'h0024);
        check_eq("R4", "stepped stack address", 32'(hist[2]), 32'h0094);
    endtask

    // R8 and register write effects seen through later moves.
    task automatic t_other();
        expect_instr("R8", 1'b0, 16'h0024, 4'h9, 4'hA, 32'h00000000, 4, 16'h0026);
        expect_instr("R4", 1'b0, 16'h0026, 4'h0, 4'h8, 32'h12345678, 4, 16'h0028);
        expect_instr("R8", 1'b0, 16'h0028, 4'h0, 4'h9, 32'h00000000, 4, 16'h002A);
        expect_instr("R6", 1'b0, 16'h002A, 4'h0, 4'h0, 32'h00000000, 4, 16'h002C);
    endtask

    initial begin
        load_program();
        t_reset();
        t_load_imm();
        t_move();
        t_load_long();
        t_branch_setup();
        t_pop();
        if (!hung) t_other();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: actual expired expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule